// File: doc/BRIEF.md
# Sequential Floating-Point Square Root Unit

This unit computes the square root of a non-negative, normalized single-precision floating-point value. It trades speed for area. One adder/subtractor runs a non-restoring root recurrence on the significand and yields one root bit per clock. The result exponent is formed in parallel by a small adder.

Before the loop starts, the significand is shifted left by zero or one bit according to the parity of the exponent. This makes the unbiased exponent even. The 24-bit root then always has its leading one in the top position, so no normalization step follows the loop. The result is truncated, not rounded.

A caller presents an operand with a one-cycle `in_valid` strobe while `busy` is low. The result comes back with a one-cycle `out_valid` pulse. An operation takes 25 cycles, counting the cycle in which the operand is presented. A new operand can be accepted every 24 cycles.

Top module: `fsq_sqrt_iter`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and `out_data` is zero.
- R2: An operand is accepted at a rising edge where `in_valid` is high and `busy` is low. `busy` is then high for the following 23 cycles and low in the 24th, so the next operand can be accepted at the 24th edge after the previous accept.
- R3: Latency. If the operand is accepted at edge E, `out_valid` is high for exactly one cycle, the cycle after edge E+24. There is one such pulse per accepted operand.
- R4: While `busy` is high, `in_valid` is ignored. It adds no pulse on `out_valid` and does not change the result of the operation in progress.
- R5: Bit 31 of the result (the sign) equals bit 31 of the operand, which is 0 for every supported input.
- R6: The result exponent (bits 30:23) equals `(e >> 1) + 63 + e[0]`, where `e` is bits 30:23 of the operand.
- R7: Result fraction. Let `m = {1, f}` be the 24-bit significand, where `f` is bits 22:0 of the operand. Form the radicand `D = m * 2^23` when `e` is odd and `D = m * 2^24` when `e` is even. Bits 22:0 of the result are the low 23 bits of `floor(sqrt(D))`. That root always lies in `[2^23, 2^24)`.
- R8: An operand whose bits 30:0 are all zero gives result `0x00000000`, with the same latency.
- R9: `out_data` holds its value between `out_valid` pulses.
- R10: Two operands accepted 24 cycles apart both give correct results, in order, 24 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| busy | output | 1 | High while a new operand cannot be accepted |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32 | Single-precision square root |

## Verification
The assertions assume every operand is non-negative and either normalized or +0. Under that assumption the sign checked on each result is zero, and any exponent field of zero in a result must mean an all-zero word. They also assume strobes arrive only while `busy` is low, except where the bench deliberately violates this to probe R4. The bench keeps its operands inside that set: positive normals across the full exponent range, including both parities and the extreme fractions, plus +0. Every strobe it drives during `busy` is one whose rejection it then checks at the outputs.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int unsigned FSQ_EXP_W  = 8;
  localparam int unsigned FSQ_FRAC_W = 23;
endpackage

// File: rtl/fsq_prep.sv
module fsq_prep #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]     operand,
  output logic [2*(FRAC_W+1)-1:0]   radicand,
  output logic [EXP_W-1:0]          exp_res,
  output logic                      sign_res,
  output logic                      is_zero
);
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned HALF_BIAS = ((1 << (EXP_W - 1)) - 1) >> 1;

  logic [EXP_W-1:0] e;
  logic [SIG_W-1:0] sig;

  assign e        = operand[EXP_W+FRAC_W-1:FRAC_W];
  assign sig      = {1'b1, operand[FRAC_W-1:0]};
  assign sign_res = operand[EXP_W+FRAC_W];
  assign is_zero  = ~|operand[EXP_W+FRAC_W-1:0];

  // Odd biased exponent means even unbiased exponent: no pre-shift.
  assign radicand = e[0] ? {1'b0, sig, {FRAC_W{1'b0}}}
                         : {sig, 1'b0, {FRAC_W{1'b0}}};

  assign exp_res = {1'b0, e[EXP_W-1:1]} + EXP_W'(HALF_BIAS) + {{(EXP_W-1){1'b0}}, e[0]};
endmodule

// File: rtl/fsq_nr_step.sv
module fsq_nr_step #(
  parameter int unsigned SIG_W = 24
) (
  input  logic [SIG_W+1:0] rem_in,
  input  logic [SIG_W-1:0] root_in,
  input  logic [1:0]       pair,
  output logic [SIG_W+1:0] rem_out,
  output logic             root_bit
);
  localparam int unsigned REM_W = SIG_W + 2;

  logic             neg;
  logic [REM_W-1:0] opa;
  logic [REM_W-1:0] opb;

  assign neg = rem_in[REM_W-1];
  assign opa = {rem_in[REM_W-3:0], pair};
  // Single adder: add {q,11} after a negative remainder, else subtract {q,01}.
  assign opb = neg ? {root_in, 2'b11} : ~{root_in, 2'b01};
  assign rem_out  = opa + opb + {{(REM_W-1){1'b0}}, ~neg};
  assign root_bit = ~rem_out[REM_W-1];
endmodule

// File: rtl/fsq_sqrt_iter.sv
module fsq_sqrt_iter #(
  parameter int unsigned EXP_W  = fsq_pkg::FSQ_EXP_W,
  parameter int unsigned FRAC_W = fsq_pkg::FSQ_FRAC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+FRAC_W:0]  in_data,
  output logic                   busy,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  out_data
);
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1;
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned RAD_W  = 2 * SIG_W;
  localparam int unsigned REM_W  = SIG_W + 2;
  localparam int unsigned CNT_W  = $clog2(SIG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_W - 1);

  logic [RAD_W-1:0]  prep_rad;
  logic [EXP_W-1:0]  prep_exp;
  logic              prep_sign;
  logic              prep_zero;

  logic [RAD_W-1:0]  rad_q;
  logic [REM_W-1:0]  rem_q;
  logic [SIG_W-1:0]  root_q;
  logic [EXP_W-1:0]  exp_q;
  logic              sign_q;
  logic              zero_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic              busy_q;
  logic              ovalid_q;
  logic [WORD_W-1:0] odata_q;

  logic [REM_W-1:0]  rem_n;
  logic              bit_n;
  logic              accept;
  logic              last;

  fsq_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prep (
    .operand  (in_data),
    .radicand (prep_rad),
    .exp_res  (prep_exp),
    .sign_res (prep_sign),
    .is_zero  (prep_zero)
  );

  fsq_nr_step #(.SIG_W(SIG_W)) u_step (
    .rem_in   (rem_q),
    .root_in  (root_q),
    .pair     (rad_q[RAD_W-1 -: 2]),
    .rem_out  (rem_n),
    .root_bit (bit_n)
  );

  assign accept = in_valid & ~busy_q;
  assign last   = active_q & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rad_q    <= '0;
      rem_q    <= '0;
      root_q   <= '0;
      exp_q    <= '0;
      sign_q   <= 1'b0;
      zero_q   <= 1'b0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      busy_q   <= 1'b0;
      ovalid_q <= 1'b0;
      odata_q  <= '0;
    end else begin
      ovalid_q <= last;
      if (last) begin
        odata_q <= zero_q ? '0 : {sign_q, exp_q, root_q[FRAC_W-2:0], bit_n};
      end
      if (accept) begin
        rad_q    <= prep_rad;
        exp_q    <= prep_exp;
        sign_q   <= prep_sign;
        zero_q   <= prep_zero;
        rem_q    <= '0;
        root_q   <= '0;
        cnt_q    <= '0;
        active_q <= 1'b1;
        busy_q   <= 1'b1;
      end else if (active_q) begin
        rad_q  <= rad_q << 2;
        rem_q  <= rem_n;
        root_q <= {root_q[SIG_W-2:0], bit_n};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST - 1'b1) busy_q <= 1'b0;
        if (last) active_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign out_valid = ovalid_q;
  assign out_data  = odata_q;
endmodule

// File: rtl/fsq_sqrt_checker.sv
module fsq_sqrt_checker #(
  parameter int unsigned EXP_W  = fsq_pkg::FSQ_EXP_W,
  parameter int unsigned FRAC_W = fsq_pkg::FSQ_FRAC_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  busy,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_data
);
  localparam int unsigned LAT   = FRAC_W + 1;
  localparam int unsigned LCW   = $clog2(LAT + 1);

  logic [LCW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else if (in_valid && !busy) left_q <= LCW'(LAT);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(left_q) == LCW'(1)));

  assert_result_due_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(left_q) == LCW'(1)) |-> out_valid);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_sign_clear_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_data[EXP_W+FRAC_W]);

  assert_zero_word_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_data[EXP_W+FRAC_W-1:FRAC_W] == '0)) |-> (out_data == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind fsq_sqrt_iter fsq_sqrt_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/fsq_sqrt_iter_bench.sv
module fsq_sqrt_iter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        busy;
  logic        out_valid;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  fsq_sqrt_iter u_fsq_sqrt_iter (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .busy (busy), .out_valid (out_valid), .out_data (out_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [31:0] ref_sqrt(input logic [31:0] x);
    logic [7:0]  e;
    logic [7:0]  er;
    longint unsigned d, lo, hi, mid;
    if (x[30:0] == 31'd0) return 32'd0;
    e = x[30:23];
    d = {40'd0, 1'b1, x[22:0]};
    d = e[0] ? (d << 23) : (d << 24);
    lo = 0;
    hi = 64'd1 << 24;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (mid * mid <= d) lo = mid; else hi = mid;
    end
    er = (e >> 1) + 8'd63 + {7'd0, e[0]};
    return {x[31], er, lo[22:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operand and waits for its result; lat counts negedges after the accept edge.
  task automatic run_op(input logic [31:0] op, output logic [31:0] res, output int lat,
                        output logic busy_first, output logic busy_24);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = op;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    busy_first = busy;
    busy_24 = 1'b1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat = lat + 1;
      if (lat == 24) busy_24 = busy;
    end
    res = out_data;
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data", out_data, 32'd0);
  endtask

  task automatic t_values;
    logic [31:0] ops [12];
    logic [31:0] res;
    int lat;
    logic b1, b24;
    ops = '{32'h3F800000, 32'h40800000, 32'h40000000, 32'h41100000,
            32'h3E800000, 32'h7F7FFFFF, 32'h00800000, 32'h3FFFFFFF,
            32'h12345678, 32'h40490FDB, 32'h00FFFFFF, 32'h7F000000};
    for (int i = 0; i < 12; i++) begin
      run_op(ops[i], res, lat, b1, b24);
      chk("R6 R7 R5 value", res, ref_sqrt(ops[i]));
      if (i == 0) begin
        chk("R3 latency", lat, 25);
        chk("R2 busy after accept", {31'd0, b1}, 32'd1);
        chk("R2 busy low in 24th cycle", {31'd0, b24}, 32'd0);
      end
    end
    run_op(32'h3F800000, res, lat, b1, b24);
    chk("R7 sqrt(1.0)", res, 32'h3F800000);
    run_op(32'h40800000, res, lat, b1, b24);
    chk("R6 sqrt(4.0)", res, 32'h40000000);
    run_op(32'h40000000, res, lat, b1, b24);
    chk("R7 sqrt(2.0) truncated", res, 32'h3FB504F3);
  endtask

  task automatic t_zero;
    logic [31:0] res;
    int lat;
    logic b1, b24;
    run_op(32'h00000000, res, lat, b1, b24);
    chk("R8 zero result", res, 32'h00000000);
    chk("R8 zero latency", lat, 25);
  endtask

  task automatic t_back_to_back;
    int n;
    int t0;
    logic [31:0] r0;
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h40490FDB;
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (busy) begin @(negedge clk); n = n + 1; end
    chk("R10 issue spacing", n, 24);
    in_valid = 1'b1;
    in_data  = 32'h41100000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 first result pulse", {31'd0, out_valid}, 32'd1);
    r0 = out_data;
    chk("R10 first value", r0, ref_sqrt(32'h40490FDB));
    t0 = 0;
    @(negedge clk);
    t0 = 1;
    while (!out_valid && t0 < 40) begin @(negedge clk); t0 = t0 + 1; end
    chk("R10 second spacing", t0, 24);
    chk("R10 second value", out_data, 32'h40400000);
  endtask

  task automatic t_ignore_busy;
    int pulses;
    logic [31:0] r;
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h3E800000;
    @(negedge clk);
    in_data  = 32'h41100000;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    pulses = 0;
    r = '0;
    for (int i = 0; i < 50; i++) begin
      if (out_valid) begin pulses = pulses + 1; r = out_data; end
      @(negedge clk);
    end
    chk("R4 one pulse only", pulses, 1);
    chk("R4 result unchanged", r, 32'h3F000000);
  endtask

  task automatic t_hold;
    logic [31:0] r;
    logic [31:0] res;
    int lat;
    logic b1, b24;
    logic same;
    run_op(32'h12345678, res, lat, b1, b24);
    r = res;
    same = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (out_data !== r || out_valid) same = 1'b0;
    end
    chk("R9 output held", {31'd0, same}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_values();
    t_zero();
    t_back_to_back();
    t_ignore_busy();
    t_hold();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule